// File: doc/BRIEF.md
# Carry-Free Signed-Digit Superaccumulator Adder

This block adds two wide fixed-point numbers. Each number is held in a redundant signed-digit form with `NCOMP` components, and the block returns their exact sum one clock later. Component `i` is a two's-complement integer of `R_BITS+2` bits with weight `2^(R_BITS*i)`. Every component of an operand must lie in the regularized range `[-(2^R_BITS - 1), 2^R_BITS - 1]`. Given that, each output component depends only on its own input pair and on the pair one index below. No carry travels more than one position, so the add time stays the same for any number of components.

Each component pair is first summed. A signed carry in {-1, 0, +1} is then chosen with a single comparison against the constant radix. That carry is taken out of the local sum and handed to the next component up. The output has `NCOMP+1` components, because the topmost carry becomes a component of its own. The result is regularized again, so it can be fed straight back as an operand of a later addition.

Data moves on a valid/ready handshake. An operand pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. A one-entry output register holds the result. `in_ready` is high when that register is empty or is being drained in the same cycle (`out_ready` high). When `out_ready` is low with a result pending, the result stays frozen and no new pair is accepted.

Top module: `sacc_cf_adder`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `sum_flat` is all zeros and `in_ready` is 1.
- R2: The value of the result, the sum over all `NCOMP+1` components of component `i` times `2^(R_BITS*i)`, equals the value of `a_flat` plus the value of `b_flat`. Component `i` occupies bits `[i*(R_BITS+2) +: R_BITS+2]` of its vector, in two's complement.
- R3: Every result component at indices 0 to `NCOMP-1` lies within `[-(2^R_BITS - 1), 2^R_BITS - 1]`.
- R4: Let `s_i` be the sum of the two input components at index `i`. The carry `c_i` is +1 when `s_i > 2^R_BITS - 2`, -1 when `s_i < -(2^R_BITS - 2)`, and 0 otherwise. Result component `i` equals `s_i - c_i*2^R_BITS + c_(i-1)`, where `c_(-1)` is 0.
- R5: Result component `NCOMP` equals `c_(NCOMP-1)`, sign-extended, and is therefore -1, 0 or +1.
- R6: A pair accepted on a rising edge shows up on `sum_flat` with `out_valid` high after that same edge.
- R7: While `out_valid` is high and `out_ready` is low, `sum_flat` and `out_valid` hold and `in_ready` is 0.
- R8: `in_ready` equals `!out_valid || out_ready`. A result drained with no new pair accepted leaves `out_valid` at 0 after that edge.
- R9: Operand values presented while `in_valid` is low, or while `in_ready` is low, have no effect on `sum_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Block can accept an operand pair |
| a_flat | input | NCOMP*(R_BITS+2) | First operand, packed components, index 0 lowest |
| b_flat | input | NCOMP*(R_BITS+2) | Second operand, packed components |
| out_valid | output | 1 | Result register holds a sum |
| out_ready | input | 1 | Consumer takes the result |
| sum_flat | output | (NCOMP+1)*(R_BITS+2) | Sum, packed components, index NCOMP on top |

## Verification
The bench aims at the carry thresholds. It uses component sums of exactly `2^R_BITS - 2` and `2^R_BITS - 1` and their negatives. A design with an off-by-one threshold gives a wrong digit or a digit outside the regularized range. It also adds all-maximum and all-minimum operands, where every position carries at once. A design that loses the top carry, or lets a carry move two places, breaks exact value equality there. Random streams with random back-pressure and garbage on idle inputs expose a result register that changes during a stall or latches unaccepted data.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  typedef enum logic [1:0] {
    CY_ZERO = 2'b00,
    CY_POS  = 2'b01,
    CY_NEG  = 2'b11
  } carry_e;

  function automatic int digit_width(input int radix_bits);
    return radix_bits + 2;
  endfunction
endpackage

// File: rtl/sacc_digit_split.sv
module sacc_digit_split
  import sacc_pkg::*;
#(
  parameter int R_BITS = 16,
  parameter int W      = R_BITS + 2
) (
  input  logic signed [W-1:0] opa,
  input  logic signed [W-1:0] opb,
  output logic signed [W-1:0] resid,
  output carry_e              cy
);
  localparam logic signed [W-1:0] RADIX = {{(W-R_BITS-1){1'b0}}, 1'b1, {R_BITS{1'b0}}};
  localparam logic signed [W-1:0] LIM   = RADIX - W'(2);
  localparam logic signed [W-1:0] NLIM  = -LIM;

  logic signed [W-1:0] raw;

  always_comb begin
    raw = opa + opb;
    if (raw > LIM) begin
      cy    = CY_POS;
      resid = raw - RADIX;
    end else if (raw < NLIM) begin
      cy    = CY_NEG;
      resid = raw + RADIX;
    end else begin
      cy    = CY_ZERO;
      resid = raw;
    end
  end
endmodule

// File: rtl/sacc_digit_merge.sv
module sacc_digit_merge
  import sacc_pkg::*;
#(
  parameter int W = 18
) (
  input  logic signed [W-1:0] resid,
  input  carry_e              cin,
  output logic signed [W-1:0] digit
);
  logic signed [W-1:0] cval;

  always_comb begin
    unique case (cin)
      CY_POS:  cval = W'(1);
      CY_NEG:  cval = '1;
      default: cval = '0;
    endcase
    digit = resid + cval;
  end
endmodule

// File: rtl/sacc_out_stage.sv
module sacc_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/sacc_cf_adder.sv
module sacc_cf_adder
  import sacc_pkg::*;
#(
  parameter int R_BITS = 16,
  parameter int NCOMP  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [NCOMP*digit_width(R_BITS)-1:0]   a_flat,
  input  logic [NCOMP*digit_width(R_BITS)-1:0]   b_flat,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [(NCOMP+1)*digit_width(R_BITS)-1:0] sum_flat
);
  localparam int W      = digit_width(R_BITS);
  localparam int OUT_DW = (NCOMP + 1) * W;

  carry_e              cy    [NCOMP];
  logic signed [W-1:0] resid [NCOMP+1];
  logic [OUT_DW-1:0]   next_sum;

  for (genvar i = 0; i < NCOMP; i++) begin : g_split
    sacc_digit_split #(.R_BITS(R_BITS), .W(W)) u_split (
      .opa  (a_flat[i*W +: W]),
      .opb  (b_flat[i*W +: W]),
      .resid(resid[i]),
      .cy   (cy[i])
    );
  end

  assign resid[NCOMP] = '0;

  for (genvar i = 0; i <= NCOMP; i++) begin : g_merge
    carry_e cin;
    if (i == 0) begin : g_low
      assign cin = CY_ZERO;
    end else begin : g_up
      assign cin = cy[i-1];
    end
    sacc_digit_merge #(.W(W)) u_merge (
      .resid(resid[i]),
      .cin  (cin),
      .digit(next_sum[i*W +: W])
    );
  end

  sacc_out_stage #(.DW(OUT_DW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (next_sum),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (sum_flat)
  );
endmodule

// File: rtl/sacc_cf_adder_chk.sv
module sacc_cf_adder_chk #(
  parameter int R_BITS = 16,
  parameter int NCOMP  = 16,
  parameter int W      = R_BITS + 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [(NCOMP+1)*W-1:0] sum_flat
);
  localparam logic signed [W-1:0] MAXD = {{(W-R_BITS){1'b0}}, {R_BITS{1'b1}}};
  localparam logic signed [W-1:0] MIND = -MAXD;

  for (genvar i = 0; i < NCOMP; i++) begin : g_rng
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(sum_flat[i*W +: W]) <= MAXD && $signed(sum_flat[i*W +: W]) >= MIND)); // R3
  end

  AST_TOP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(sum_flat[NCOMP*W +: W]) <= W'(1) && $signed(sum_flat[NCOMP*W +: W]) >= -W'(1))); // R5

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(sum_flat))); // R7

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8
endmodule

bind sacc_cf_adder sacc_cf_adder_chk #(.R_BITS(R_BITS), .NCOMP(NCOMP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .sum_flat (sum_flat)
);

// File: tb/tb_sacc_cf_adder.sv
module tb_sacc_cf_adder;
  localparam int RB = 16;
  localparam int K  = 16;
  localparam int W  = RB + 2;
  localparam int R  = 1 << RB;
  localparam int VW = (K + 1) * RB + 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [K*W-1:0]     a_flat = '0;
  logic [K*W-1:0]     b_flat = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [(K+1)*W-1:0] sum_flat;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic               exp_valid = 1'b0;
  logic [(K+1)*W-1:0] exp_sum = '0;
  logic signed [VW-1:0] exp_val = '0;

  always #5 clk = ~clk;

  sacc_cf_adder #(.R_BITS(RB), .NCOMP(K)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_flat(a_flat), .b_flat(b_flat), .out_valid(out_valid),
    .out_ready(out_ready), .sum_flat(sum_flat)
  );

  function automatic logic [(K+1)*W-1:0] ref_add(input logic [K*W-1:0] a, input logic [K*W-1:0] b);
    logic [(K+1)*W-1:0] r;
    int cprev;
    cprev = 0;
    r = '0;
    for (int i = 0; i < K; i++) begin
      int s, c, d;
      s = int'($signed(a[i*W +: W])) + int'($signed(b[i*W +: W]));
      c = (s > R - 2) ? 1 : ((s < -(R - 2)) ? -1 : 0);
      d = s - c * R + cprev;
      r[i*W +: W] = d[W-1:0];
      cprev = c;
    end
    r[K*W +: W] = W'(cprev);
    return r;
  endfunction

  function automatic logic signed [VW-1:0] value_of(input logic [(K+1)*W-1:0] v, input int n);
    logic signed [VW-1:0] acc;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      logic signed [VW-1:0] t;
      t = VW'($signed(v[i*W +: W]));
      acc = acc + (t <<< (RB * i));
    end
    return acc;
  endfunction

  // Behavioural reference model, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_sum   <= '0;
      exp_val   <= '0;
    end else if (in_valid && (!exp_valid || out_ready)) begin
      exp_valid <= 1'b1;
      exp_sum   <= ref_add(a_flat, b_flat);
      exp_val   <= value_of({{W{1'b0}}, a_flat}, K) + value_of({{W{1'b0}}, b_flat}, K);
    end else if (out_ready) begin
      exp_valid <= 1'b0;
    end
  end

  // Comparison away from the edge
  always begin
    @(negedge clk);
    #1;
    if (!done) begin
      vectors++;
      if (!rst_n) begin
        if (out_valid !== 1'b0 || sum_flat !== '0 || in_ready !== 1'b1) begin
          miscompares++;
          $display("FAIL R1 reset state: out_valid=%b in_ready=%b sum=%h expected 0 1 0", out_valid, in_ready, sum_flat);
        end
      end else begin
        if (out_valid !== exp_valid) begin
          miscompares++;
          $display("FAIL R6 R7 R8 out_valid=%b expected %b", out_valid, exp_valid);
        end
        if (in_ready !== (!exp_valid || out_ready)) begin
          miscompares++;
          $display("FAIL R8 in_ready=%b expected %b", in_ready, (!exp_valid || out_ready));
        end
        if (exp_valid) begin
          if (sum_flat[(K+1)*W-1:K*W] !== exp_sum[(K+1)*W-1:K*W]) begin
            miscompares++;
            $display("FAIL R5 top component=%h expected %h", sum_flat[(K+1)*W-1:K*W], exp_sum[(K+1)*W-1:K*W]);
          end
          if (sum_flat[K*W-1:0] !== exp_sum[K*W-1:0]) begin
            miscompares++;
            $display("FAIL R4 R7 R9 sum=%h expected %h", sum_flat, exp_sum);
          end
          if (value_of(sum_flat, K + 1) !== exp_val) begin
            miscompares++;
            $display("FAIL R2 value=%h expected %h", value_of(sum_flat, K + 1), exp_val);
          end
          for (int i = 0; i < K; i++) begin
            if ($signed(sum_flat[i*W +: W]) > (R - 1) || $signed(sum_flat[i*W +: W]) < -(R - 1)) begin
              miscompares++;
              $display("FAIL R3 component %0d=%0d expected within +-%0d", i, $signed(sum_flat[i*W +: W]), R - 1);
            end
          end
        end
      end
    end
  end

  task automatic put_digit(input int i, input int va, input int vb);
    a_flat[i*W +: W] = W'(va);
    b_flat[i*W +: W] = W'(vb);
  endtask

  task automatic fill(input int va, input int vb);
    for (int i = 0; i < K; i++) put_digit(i, va, vb);
  endtask

  task automatic fill_random;
    for (int i = 0; i < K; i++)
      put_digit(i, int'($urandom_range(2 * R - 2)) - (R - 1), int'($urandom_range(2 * R - 2)) - (R - 1));
  endtask

  task automatic send_one;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);          // R1 checked during reset
    rst_n = 1'b1;
    @(negedge clk);

    fill(0, 0); send_one;                              // zeros
    fill(R - 1, R - 1); send_one;                      // every position carries +1 (R4, R5)
    fill(-(R - 1), -(R - 1)); send_one;                // every position carries -1
    for (int i = 0; i < K; i++)                        // thresholds R-2 / R-1 (R4)
      if (i % 2 == 0) put_digit(i, R - 2, 0); else put_digit(i, R - 2, 1);
    send_one;
    for (int i = 0; i < K; i++)                        // negative thresholds
      if (i % 2 == 0) put_digit(i, -(R - 2), 0); else put_digit(i, -(R - 2), -1);
    send_one;
    for (int i = 0; i < K; i++)                        // mixed sign carries
      put_digit(i, (i % 3 == 0) ? R - 1 : -(R - 1), (i % 3 == 1) ? -(R - 1) : R - 3);
    send_one;

    // Stall: result must hold and new data is refused (R7, R9)
    fill(R - 1, 1);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    fill_random;
    repeat (4) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;

    // Garbage on idle inputs (R9)
    for (int j = 0; j < 5; j++) begin
      fill_random;
      @(negedge clk);
    end

    // Random stream with back-pressure (R2 R3 R4 R6 R8)
    for (int j = 0; j < 300; j++) begin
      fill_random;
      in_valid  = ($urandom_range(3) != 0);
      out_ready = ($urandom_range(3) != 0);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL R6 watchdog: run still active=1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule